// File: doc/BRIEF.md
# Three-and-a-half-digit LCD segment driver

This block turns a latched binary reading into segment drive for a static seven-segment liquid crystal display with three full digits (hundreds, tens, ones), a leading half digit that can show only a "1", and a minus sign. It produces the backplane square wave itself, dividing the input clock down. Every segment output either follows the backplane (segment dark) or its complement (segment visible). As a result, in normal operation no net DC voltage builds up across the glass.

A reading is presented on `mag_i` with its sign and range flags and strobed in with `load_i`. A sequential shift-and-add-3 converter turns the magnitude into decimal digits over several clocks. The visible display is held at the previous reading until the conversion finishes, so it never shows a half-converted value. A test input overrides everything and lights all segments with a static level, so the display reads -1888.

Top module: `lcd_halfdigit_drv`

## Requirements
- R1: After reset `bp_o` is low. It first goes high at the 400th rising clock edge after reset is released and then toggles every 400 clocks, giving a 50% square wave of period 800 clocks (CLK_DIV).
- R2: Each segment output equals `bp_o` when the segment is dark and `~bp_o` when it is lit. Within a digit bit 0 is segment a and bit 6 is segment g. The lit patterns for 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R3: For an in-range reading the ones, tens and hundreds outputs show the decimal digits of the magnitude, with zeros shown. The half digit is lit exactly when the magnitude is 1000 or more.
- R4: The minus segment is lit exactly when the latched polarity flag is set. This also holds for an overrange reading.
- R5: A reading is overrange when `ovr_i` is set or the magnitude exceeds 1999. In that case the half digit is lit and all three full digits are dark.
- R6: The edge that samples `load_i` high starts a conversion. The outputs switch to the new reading on the 12th rising edge after that edge. Up to then they keep showing the previous reading.
- R7: A `load_i` strobe that arrives while a conversion is in progress is ignored. Its value never reaches the display.
- R8: While `test_i` is high, `bp_o` is held low and every segment output, the minus and half digit included, is held high. When `test_i` drops, AC drive of the latched reading resumes.
- R9: After reset and before the first completed conversion, every segment is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Strobe that latches a new reading |
| mag_i | input | MAG_W (11) | Binary magnitude of the reading |
| neg_i | input | 1 | Polarity flag, 1 for negative |
| ovr_i | input | 1 | Overrange flag |
| test_i | input | 1 | Display test, lights all segments with DC levels |
| bp_o | output | 1 | Backplane square wave |
| seg_half_o | output | 1 | Half digit drive (segments b and c together) |
| seg_hund_o | output | 7 | Hundreds digit drive, bit 0 = a |
| seg_tens_o | output | 7 | Tens digit drive, bit 0 = a |
| seg_ones_o | output | 7 | Ones digit drive, bit 0 = a |
| seg_minus_o | output | 1 | Minus sign drive |

## Verification
The bench measures the first backplane edge and the half period after reset. An off-by-one divider would put these at 399 or 401 clocks. It covers the digit boundaries 0, 999, 1000, 1999 and 2000, where a broken add-3 correction or a wrong half-digit rule would show a wrong digit or a missing "1". It also checks that the old reading holds on the 11th edge after a load and changes on the 12th, and that a second strobe during a conversion is dropped rather than restarting the conversion. Test mode is checked for static levels rather than inverted AC drive, and the bench confirms that leaving it returns the latched reading.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

   localparam int SEG_N = 7;

   typedef logic [SEG_N-1:0] seg_t;

   // lit pattern of a decimal digit, bit 0 = segment a ... bit 6 = segment g
   function automatic seg_t digit_font(input logic [3:0] d);
      seg_t s;
      case (d)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcdh_bp_div.sv
module lcdh_bp_div #(
   parameter int DIV = 800
) (
   input  logic clk,
   input  logic rst,
   output logic bp_o
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (DIV % 2 != 0 || DIV < 4) begin : g_bad_div
      $error("lcdh_bp_div: DIV must be even and at least 4");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         bp_o <= 1'b0;
      end else if (cnt == CW'(HALF - 1)) begin
         cnt  <= '0;
         bp_o <= ~bp_o;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // counter never leaves the half-period window (R1)
   assert_cnt_window_R1: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(HALF - 1));

   // backplane only changes right after the counter wrapped (R1)
   assert_bp_edge_at_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (bp_o != $past(bp_o)) |-> (cnt == '0));

endmodule

// File: rtl/lcdh_bin2bcd.sv
module lcdh_bin2bcd #(
   parameter int BIN_W = 11,
   parameter int NDIG  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [BIN_W-1:0]  bin_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [4*NDIG-1:0] bcd_o
);
   localparam int BW = 4 * NDIG;
   localparam int IW = $clog2(BIN_W);

   if (BIN_W < 2 || NDIG < 1) begin : g_bad_cfg
      $error("lcdh_bin2bcd: BIN_W must be at least 2 and NDIG at least 1");
   end

   logic [BIN_W-1:0] sh;
   logic [BW-1:0]    acc;
   logic [BW-1:0]    adj;
   logic [IW-1:0]    it;
   logic             digits_ok;

   // add-3 correction of every nibble that would overflow on doubling
   always_comb begin
      adj = acc;
      for (int k = 0; k < NDIG; k++) begin
         if (adj[4*k +: 4] > 4'd4) adj[4*k +: 4] = adj[4*k +: 4] + 4'd3;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         it     <= '0;
         sh     <= '0;
         acc    <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy_o) begin
            sh     <= bin_i;
            acc    <= '0;
            it     <= '0;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            acc <= {adj[BW-2:0], sh[BIN_W-1]};
            sh  <= sh << 1;
            it  <= it + 1'b1;
            if (it == IW'(BIN_W - 1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign bcd_o = acc;

   always_comb begin
      digits_ok = 1'b1;
      for (int k = 0; k < NDIG; k++) begin
         if (acc[4*k +: 4] > 4'd9) digits_ok = 1'b0;
      end
   end

   // a finished conversion holds only decimal digits (R3)
   assert_decimal_digits_R3: assert property (@(posedge clk) disable iff (rst)
      done_o |-> digits_ok);

   // done is a single pulse that follows a busy period (R6)
   assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
      done_o |-> ($past(busy_o) && !busy_o));

endmodule

// File: rtl/lcdh_seg_drive.sv
module lcdh_seg_drive #(
   parameter int W = 7
) (
   input  logic [W-1:0] lit_i,
   input  logic         bp_i,
   input  logic         test_i,
   output logic [W-1:0] seg_o
);
   if (W < 1) begin : g_bad_w
      $error("lcdh_seg_drive: W must be positive");
   end

   // dark = in phase with backplane, lit = antiphase; test forces static high
   always_comb begin
      if (test_i) seg_o = '1;
      else        seg_o = lit_i ^ {W{bp_i}};
   end

endmodule

// File: rtl/lcd_halfdigit_drv.sv
module lcd_halfdigit_drv
   import lcdh_pkg::*;
#(
   parameter int CLK_DIV  = 800,
   parameter int MAG_W    = 11,
   parameter int MAX_READ = 1999
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [MAG_W-1:0] mag_i,
   input  logic             neg_i,
   input  logic             ovr_i,
   input  logic             test_i,
   output logic             bp_o,
   output logic             seg_half_o,
   output logic [6:0]       seg_hund_o,
   output logic [6:0]       seg_tens_o,
   output logic [6:0]       seg_ones_o,
   output logic             seg_minus_o
);
   localparam int NFULL = 3;
   localparam int NDIG  = NFULL + 1;
   localparam int BW    = 4 * NDIG;

   if ((2 ** MAG_W) <= MAX_READ) begin : g_bad_mag
      $error("lcd_halfdigit_drv: MAG_W too narrow for MAX_READ");
   end
   if (MAX_READ > 1999) begin : g_bad_max
      $error("lcd_halfdigit_drv: half digit can only show 1");
   end

   logic          bp;
   logic          conv_busy;
   logic          conv_done;
   logic [BW-1:0] bcd;

   // values captured with the strobe, committed when the digits are ready
   logic          p_neg, p_ovr;
   logic          d_valid, d_neg, d_ovr, d_half;
   logic [3:0]    d_dig [NFULL];

   seg_t          lit_full [NFULL];
   seg_t          seg_full [NFULL];
   logic          lit_half, lit_minus;
   logic          bp_eff;

   lcdh_bp_div #(.DIV(CLK_DIV)) u_bp (
      .clk  (clk),
      .rst  (rst),
      .bp_o (bp)
   );

   lcdh_bin2bcd #(.BIN_W(MAG_W), .NDIG(NDIG)) u_conv (
      .clk     (clk),
      .rst     (rst),
      .start_i (load_i),
      .bin_i   (mag_i),
      .busy_o  (conv_busy),
      .done_o  (conv_done),
      .bcd_o   (bcd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         p_neg   <= 1'b0;
         p_ovr   <= 1'b0;
         d_valid <= 1'b0;
         d_neg   <= 1'b0;
         d_ovr   <= 1'b0;
         d_half  <= 1'b0;
         for (int k = 0; k < NFULL; k++) d_dig[k] <= '0;
      end else begin
         if (load_i && !conv_busy) begin
            p_neg <= neg_i;
            p_ovr <= ovr_i || (mag_i > MAG_W'(MAX_READ));
         end
         if (conv_done) begin
            d_valid <= 1'b1;
            d_neg   <= p_neg;
            d_ovr   <= p_ovr;
            d_half  <= (bcd[BW-1 -: 4] != 4'd0);
            for (int k = 0; k < NFULL; k++) d_dig[k] <= bcd[4*k +: 4];
         end
      end
   end

   always_comb begin
      lit_half  = d_valid && (d_ovr || d_half);
      lit_minus = d_valid && d_neg;
      bp_eff    = test_i ? 1'b0 : bp;
   end

   for (genvar k = 0; k < NFULL; k++) begin : g_digit
      assign lit_full[k] = (d_valid && !d_ovr) ? digit_font(d_dig[k]) : '0;

      lcdh_seg_drive #(.W(SEG_N)) u_drv (
         .lit_i  (lit_full[k]),
         .bp_i   (bp),
         .test_i (test_i),
         .seg_o  (seg_full[k])
      );
   end

   lcdh_seg_drive #(.W(1)) u_half (
      .lit_i  (lit_half),
      .bp_i   (bp),
      .test_i (test_i),
      .seg_o  (seg_half_o)
   );

   lcdh_seg_drive #(.W(1)) u_minus (
      .lit_i  (lit_minus),
      .bp_i   (bp),
      .test_i (test_i),
      .seg_o  (seg_minus_o)
   );

   assign bp_o       = bp_eff;
   assign seg_ones_o = seg_full[0];
   assign seg_tens_o = seg_full[1];
   assign seg_hund_o = seg_full[2];

   // ---------------------------------------------------------------- checks
   logic [16:0] disp_vec;
   assign disp_vec = {d_valid, d_neg, d_ovr, d_half, d_dig[2], d_dig[1], d_dig[0]};

   // displayed reading never moves while a conversion is running (R6)
   assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
      (conv_busy && $past(conv_busy)) |-> $stable(disp_vec));

   // a busy converter keeps its pending flags despite new strobes (R7)
   assert_strobe_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(conv_busy) && $past(load_i)) |-> ($stable(p_neg) && $stable(p_ovr)));

   // with a steady reading, every segment flips with the backplane (R2)
   assert_ac_follow_R2: assert property (@(posedge clk) disable iff (rst)
      (!test_i && $past(!test_i) && (bp_o != $past(bp_o)) && $stable(disp_vec))
      |-> (seg_ones_o == ~$past(seg_ones_o) && seg_minus_o == ~$past(seg_minus_o)));

   // test mode is static: backplane low, every segment high (R8)
   assert_test_static_R8: assert property (@(posedge clk) disable iff (rst)
      test_i |-> (!bp_o && seg_half_o && seg_minus_o && (&seg_ones_o)
                  && (&seg_tens_o) && (&seg_hund_o)));

   // overrange blanks full digits: they sit in phase with backplane (R5)
   assert_ovr_blank_R5: assert property (@(posedge clk) disable iff (rst)
      (d_valid && d_ovr && !test_i) |->
      (seg_ones_o == {7{bp_o}} && seg_hund_o == {7{bp_o}} && seg_half_o == ~bp_o));

endmodule

// File: tb/lcd_halfdigit_drv_tb_top.sv
`timescale 1ns/1ps
module lcd_halfdigit_drv_tb_top;

   typedef struct {
      logic [6:0] hund, tens, ones;
      logic       half, minus;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_i = 1'b0;
   logic [10:0] mag_i = '0;
   logic        neg_i = 1'b0;
   logic        ovr_i = 1'b0;
   logic        test_i = 1'b0;
   logic        bp_o, seg_half_o, seg_minus_o;
   logic [6:0]  seg_hund_o, seg_tens_o, seg_ones_o;

   int   n_checks = 0;
   int   n_fail   = 0;
   exp_t sb_q[$];
   event sample_ev;

   always #2.5 clk = ~clk;

   lcd_halfdigit_drv dut_i (
      .clk(clk), .rst(rst), .load_i(load_i), .mag_i(mag_i), .neg_i(neg_i),
      .ovr_i(ovr_i), .test_i(test_i), .bp_o(bp_o), .seg_half_o(seg_half_o),
      .seg_hund_o(seg_hund_o), .seg_tens_o(seg_tens_o), .seg_ones_o(seg_ones_o),
      .seg_minus_o(seg_minus_o)
   );

   function automatic logic [6:0] font(input int d);
      case (d)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; default: return 7'h6F;
      endcase
   endfunction

   function automatic exp_t model(input int mag, input bit neg, input bit ovr);
      exp_t e;
      e.minus = neg;
      if (ovr || mag > 1999) begin
         e.half = 1'b1; e.hund = '0; e.tens = '0; e.ones = '0;
      end else begin
         e.half = (mag >= 1000);
         e.hund = font((mag / 100) % 10);
         e.tens = font((mag / 10) % 10);
         e.ones = font(mag % 10);
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops the next expected display and compares lit state
   initial begin
      forever begin
         @(sample_ev);
         if (sb_q.size() > 0) begin
            exp_t e;
            logic [6:0] m7;
            e  = sb_q.pop_front();
            m7 = {7{bp_o}};
            check((seg_hund_o ^ m7) == e.hund, "R3/R5 hundreds", int'(seg_hund_o ^ m7), int'(e.hund));
            check((seg_tens_o ^ m7) == e.tens, "R3/R5 tens", int'(seg_tens_o ^ m7), int'(e.tens));
            check((seg_ones_o ^ m7) == e.ones, "R3/R5 ones", int'(seg_ones_o ^ m7), int'(e.ones));
            check((seg_half_o ^ bp_o) == e.half, "R3/R5 half digit", int'(seg_half_o ^ bp_o), int'(e.half));
            check((seg_minus_o ^ bp_o) == e.minus, "R4 minus", int'(seg_minus_o ^ bp_o), int'(e.minus));
         end
      end
   end

   task automatic sample(input exp_t e);
      sb_q.push_back(e);
      -> sample_ev;
      #1;
   endtask

   // driver: strobe a reading, wait for the conversion, hand over the expectation
   task automatic show(input int mag, input bit neg, input bit ovr);
      @(negedge clk);
      mag_i = 11'(mag); neg_i = neg; ovr_i = ovr; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
      repeat (14) @(negedge clk);
      sample(model(mag, neg, ovr));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // reset state: backplane low, all dark (R9)
      check(bp_o == 1'b0, "R1 reset backplane", int'(bp_o), 0);
      rst = 1'b0;
      sample('{hund: '0, tens: '0, ones: '0, half: 1'b0, minus: 1'b0});   // R9

      // R1: first rise on the 400th edge, then half period 400
      begin
         int n = 0;
         do begin @(negedge clk); n++; end while (bp_o == 1'b0 && n < 2000);
         check(n == 400, "R1 first rise", n, 400);
         n = 0;
         do begin @(negedge clk); n++; end while (bp_o == 1'b1 && n < 2000);
         check(n == 400, "R1 half period", n, 400);
      end

      show(0, 0, 0);
      show(7, 0, 0);
      show(42, 1, 0);
      show(999, 0, 0);
      show(1000, 0, 0);
      show(1999, 1, 0);
      show(1234, 1, 0);
      show(500, 0, 1);        // R5 flagged
      show(2000, 0, 0);       // R5 by magnitude
      show(2047, 1, 0);       // R5 and R4

      // R2: raw levels of a lit "8" in both backplane phases
      show(8, 0, 0);
      wait (bp_o == 1'b0); @(negedge clk);
      check(seg_ones_o == 7'h7F && seg_tens_o == 7'h3F, "R2 lit vs bp low", int'(seg_ones_o), 'h7F);
      wait (bp_o == 1'b1); @(negedge clk);
      check(seg_ones_o == 7'h00 && seg_tens_o == 7'h40, "R2 lit vs bp high", int'(seg_ones_o), 'h00);

      // R6: old value on the 11th edge after the sampling edge, new on the 12th
      @(negedge clk);
      mag_i = 11'd365; neg_i = 1'b0; ovr_i = 1'b0; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
      repeat (11) @(negedge clk);
      check((seg_ones_o ^ {7{bp_o}}) == font(8), "R6 hold before update",
            int'(seg_ones_o ^ {7{bp_o}}), int'(font(8)));
      @(negedge clk);
      check((seg_ones_o ^ {7{bp_o}}) == font(5), "R6 update on 12th edge",
            int'(seg_ones_o ^ {7{bp_o}}), int'(font(5)));

      // R7: a strobe during conversion is dropped
      @(negedge clk);
      mag_i = 11'd111; neg_i = 1'b0; load_i = 1'b1;
      @(negedge clk);
      mag_i = 11'd1888; neg_i = 1'b1;
      repeat (3) @(negedge clk);
      load_i = 1'b0;
      repeat (14) @(negedge clk);
      sample(model(111, 0, 0));   // R7

      // R8: test mode is static -1888
      @(negedge clk); test_i = 1'b1;
      repeat (3) @(negedge clk);
      check(bp_o == 1'b0, "R8 backplane held low", int'(bp_o), 0);
      check(seg_ones_o == 7'h7F && seg_tens_o == 7'h7F && seg_hund_o == 7'h7F,
            "R8 digits all high", int'(seg_hund_o), 'h7F);
      check(seg_half_o && seg_minus_o, "R8 half and minus high",
            int'({seg_half_o, seg_minus_o}), 3);
      @(negedge clk); test_i = 1'b0;
      @(negedge clk);
      sample(model(111, 0, 0));   // R8 release returns the latched reading

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #500000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule